// File: doc/BRIEF.md
# Mutation-Driven Hill-Climbing Search Engine

This block runs a parallel hill-climbing search over a small population of bit-string chromosomes. After a host loads a seed, a mutation strength and a generation limit, a start pulse fills every population slot with pseudo-random bits from an internal shift-register generator and zeroes the stored scores. The engine then visits the slots in a fixed round-robin order. For each slot it flips a configurable number of randomly chosen bits of the stored chromosome and emits the result as a candidate on a valid-qualified output stream. An external evaluator, not part of this block, consumes the candidates.

The evaluator returns one score per candidate, in the order the candidates were issued. Every emitted candidate is also held in a small in-flight queue, so the engine keeps issuing new candidates while older ones are still being scored. When a score arrives for the candidate at the head of the queue, it is compared with the stored score of that candidate's parent slot. A strictly higher score writes the candidate and its score into the slot. Any other score drops the candidate. The run ends after the programmed number of full passes over the population has been issued and scored.

Top module: `hill_climber`

## Requirements
- R1: After reset, `cand_valid` and `done` are 0 and `gen_count` is 0.
- R2: The random source is a 32-bit Galois generator. Each step shifts the state right by one bit and, when the bit shifted out was 1, XORs the state with 32'h80200003. `cfg_load`, while the engine is idle or finished, loads `cfg_seed`. A seed of zero is replaced by 1.
- R3: On `start`, slot i (i = 0 .. POP_N-1) receives the low CHROM_W bits of the generator state after i+1 steps, and every stored score becomes 0.
- R4: Candidates are issued for slots 0, 1, .., POP_N-1, and this pass repeats once per generation. Each candidate is the slot's current chromosome XOR a mask built from `cfg_flips` draws. Each draw steps the generator once and takes its low 5 bits as a position p; if p is CHROM_W or more, CHROM_W is subtracted. The draw toggles mask bit p, so a repeated position cancels itself. A score accepted in the same cycle is already visible in the chromosome used.
- R5: Each candidate appears as a single-cycle pulse of `cand_valid`, with the chromosome on `cand_data`.
- R6: At most FIFO_DEPTH candidates are unscored at any time. Issue waits while that many are outstanding, and new candidates are issued before earlier ones have been scored.
- R7: A returned score replaces the parent slot's chromosome and score only if it is strictly greater than the stored score, compared unsigned. An equal or lower score leaves the slot unchanged.
- R8: A `fit_valid` pulse while no candidate is outstanding is ignored.
- R9: `gen_count` increments each time the score for slot POP_N-1 is retired. `done` rises once `cfg_gens` generations are issued and every candidate is scored, and stays high until the next `start`. With `cfg_gens` = 0, `done` rises after initialisation and no candidate is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load seed, flip count and generation limit (idle or finished only) |
| cfg_seed | input | 32 | Generator seed |
| cfg_flips | input | FLIP_W | Bits toggled per candidate |
| cfg_gens | input | GEN_W | Number of generations to run |
| start | input | 1 | Begin initialisation and search |
| done | output | 1 | Run finished, all candidates scored |
| gen_count | output | GEN_W | Fully scored generations |
| cand_valid | output | 1 | Candidate present on `cand_data` |
| cand_data | output | CHROM_W | Candidate chromosome |
| fit_valid | input | 1 | Score present on `fit_value` |
| fit_value | input | FIT_W | Score of the oldest outstanding candidate |

## Verification
Several patterns exercise the main search loop, and each one isolates a different part of it. A zero-flip run with seed zero shows the initial population exactly, which checks the seed substitution and the generator fill order. A five-flip run with slow score returns and a mixed score table (higher, equal and lower values) checks the mutation masks, the in-flight limit and the strict replacement rule together. A zero-flip run in which every score ties, with spurious score pulses while nothing is outstanding, shows that parents never change, and a zero-generation run checks the early finish.

// File: rtl/climb_pkg.sv
package climb_pkg;

    localparam int RNG_W = 32;
    localparam logic [RNG_W-1:0] RNG_TAPS = 32'h80200003;

    typedef enum logic [2:0] {
        S_IDLE,
        S_INIT,
        S_LOAD,
        S_FLIP,
        S_EMIT,
        S_DRAIN,
        S_DONE
    } climb_state_e;

    function automatic logic [RNG_W-1:0] rng_next(input logic [RNG_W-1:0] s);
        logic [RNG_W-1:0] r;
        r = s >> 1;
        if (s[0]) begin
            r = r ^ RNG_TAPS;
        end
        return r;
    endfunction

endpackage

// File: rtl/climb_lfsr.sv
module climb_lfsr
    import climb_pkg::*;
#(
    parameter int OUT_W = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [RNG_W-1:0]     seed,
    input  logic                 step,
    output logic [OUT_W-1:0]     draw
);

    logic [RNG_W-1:0] state_d, state_q;
    logic [RNG_W-1:0] stepped;

    always_comb begin
        stepped = rng_next(state_q);
        state_d = state_q;
        if (load) begin
            state_d = (seed == '0) ? RNG_W'(1) : seed;
        end else if (step) begin
            state_d = stepped;
        end
        draw = stepped[OUT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RNG_W'(1);
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/climb_fifo.sv
module climb_fifo #(
    parameter int W     = 28,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     slots_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q, wr_d, rd_d, wr_inc, rd_inc;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             do_push, do_pop;

    generate
        if ((1 << PTR_W) == DEPTH) begin : g_pow2
            assign wr_inc = wr_q + 1'b1;
            assign rd_inc = rd_q + 1'b1;
        end else begin : g_wrap
            assign wr_inc = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            assign rd_inc = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
        end
    endgenerate

    always_comb begin
        full    = (cnt_q == CNT_W'(DEPTH));
        empty   = (cnt_q == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        wr_d    = do_push ? wr_inc : wr_q;
        rd_d    = do_pop ? rd_inc : rd_q;
        cnt_d   = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
        rdata   = slots_q[rd_q];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            wr_q  <= wr_d;
            rd_q  <= rd_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            slots_q[wr_q] <= wdata;
        end
    end

endmodule

// File: rtl/climb_store.sv
module climb_store #(
    parameter int POP_N   = 16,
    parameter int CHROM_W = 24,
    parameter int FIT_W   = 16,
    parameter int SLOT_W  = 4
) (
    input  logic               clk,
    input  logic               we,
    input  logic [SLOT_W-1:0]  wslot,
    input  logic [CHROM_W-1:0] wchrom,
    input  logic [FIT_W-1:0]   wfit,
    input  logic [SLOT_W-1:0]  chrom_addr,
    output logic [CHROM_W-1:0] chrom_rd,
    input  logic [SLOT_W-1:0]  fit_addr,
    output logic [FIT_W-1:0]   fit_rd
);

    logic [CHROM_W-1:0] chrom_q [POP_N];
    logic [FIT_W-1:0]   fit_q   [POP_N];

    for (genvar i = 0; i < POP_N; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (wslot == SLOT_W'(i))) begin
                chrom_q[i] <= wchrom;
                fit_q[i]   <= wfit;
            end
        end
    end

    assign chrom_rd = chrom_q[chrom_addr];
    assign fit_rd   = fit_q[fit_addr];

endmodule

// File: rtl/hill_climber.sv
module hill_climber
    import climb_pkg::*;
#(
    parameter int CHROM_W    = 24,
    parameter int POP_N      = 16,
    parameter int FIT_W      = 16,
    parameter int FIFO_DEPTH = 4,
    parameter int FLIP_W     = 4,
    parameter int GEN_W      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_load,
    input  logic [31:0]        cfg_seed,
    input  logic [FLIP_W-1:0]  cfg_flips,
    input  logic [GEN_W-1:0]   cfg_gens,
    input  logic               start,
    output logic               done,
    output logic [GEN_W-1:0]   gen_count,
    output logic               cand_valid,
    output logic [CHROM_W-1:0] cand_data,
    input  logic               fit_valid,
    input  logic [FIT_W-1:0]   fit_value
);

    localparam int SLOT_W = (POP_N > 1) ? $clog2(POP_N) : 1;
    localparam int IDX_W  = (CHROM_W > 1) ? $clog2(CHROM_W) : 1;
    localparam int ENT_W  = CHROM_W + SLOT_W;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(POP_N - 1);

    typedef struct packed {
        climb_state_e       st;
        logic [FLIP_W-1:0]  flips_cfg;
        logic [GEN_W-1:0]   gens_cfg;
        logic [SLOT_W-1:0]  slot;
        logic [FLIP_W-1:0]  flips_left;
        logic [CHROM_W-1:0] mask;
        logic [GEN_W-1:0]   issue_gen;
        logic [GEN_W-1:0]   gen_count;
        logic               done;
        logic               cand_valid;
        logic [CHROM_W-1:0] cand_data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // generator
    logic               rng_load, rng_step;
    logic [CHROM_W-1:0] rng_draw;

    // in-flight queue
    logic               q_push, q_pop, q_full, q_empty;
    logic [ENT_W-1:0]   q_wdata, q_rdata;
    logic [CHROM_W-1:0] head_chrom;
    logic [SLOT_W-1:0]  head_slot;

    // population store
    logic               st_we;
    logic [SLOT_W-1:0]  st_wslot;
    logic [CHROM_W-1:0] st_wchrom, parent_rd, parent;
    logic [FIT_W-1:0]   st_wfit, parent_fit;

    // retire / mutate helpers
    logic               retire, accept, init_we;
    logic [IDX_W:0]     pos_wide;
    logic [IDX_W-1:0]   flip_pos;
    logic [GEN_W-1:0]   gen_next;
    logic [CHROM_W-1:0] candidate;

    climb_lfsr #(.OUT_W(CHROM_W)) i_rng (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rng_load),
        .seed  (cfg_seed),
        .step  (rng_step),
        .draw  (rng_draw)
    );

    climb_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) i_inflight (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .wdata (q_wdata),
        .pop   (q_pop),
        .rdata (q_rdata),
        .full  (q_full),
        .empty (q_empty)
    );

    climb_store #(
        .POP_N   (POP_N),
        .CHROM_W (CHROM_W),
        .FIT_W   (FIT_W),
        .SLOT_W  (SLOT_W)
    ) i_store (
        .clk        (clk),
        .we         (st_we),
        .wslot      (st_wslot),
        .wchrom     (st_wchrom),
        .wfit       (st_wfit),
        .chrom_addr (ctl_q.slot),
        .chrom_rd   (parent_rd),
        .fit_addr   (head_slot),
        .fit_rd     (parent_fit)
    );

    always_comb begin
        ctl_d            = ctl_q;
        ctl_d.cand_valid = 1'b0;

        {head_chrom, head_slot} = q_rdata;

        // retire side: runs alongside issue
        retire = fit_valid && !q_empty;
        accept = retire && (fit_value > parent_fit);
        q_pop  = retire;
        if (retire && (head_slot == LAST_SLOT)) begin
            ctl_d.gen_count = ctl_q.gen_count + 1'b1;
        end

        // parent seen by the issue side includes a same-cycle acceptance
        parent = (accept && (head_slot == ctl_q.slot)) ? head_chrom : parent_rd;

        // flip position from one draw, folded into range
        pos_wide = {1'b0, rng_draw[IDX_W-1:0]};
        if (pos_wide >= (IDX_W+1)'(CHROM_W)) begin
            pos_wide = pos_wide - (IDX_W+1)'(CHROM_W);
        end
        flip_pos = pos_wide[IDX_W-1:0];

        candidate = parent ^ ctl_q.mask;
        gen_next  = ctl_q.issue_gen + 1'b1;

        rng_load = 1'b0;
        rng_step = 1'b0;
        init_we  = 1'b0;
        q_push   = 1'b0;
        q_wdata  = {candidate, ctl_q.slot};

        unique case (ctl_q.st)
            S_IDLE, S_DONE: begin
                if (cfg_load) begin
                    rng_load        = 1'b1;
                    ctl_d.flips_cfg = cfg_flips;
                    ctl_d.gens_cfg  = cfg_gens;
                end
                if (start) begin
                    ctl_d.st        = S_INIT;
                    ctl_d.slot      = '0;
                    ctl_d.issue_gen = '0;
                    ctl_d.gen_count = '0;
                    ctl_d.done      = 1'b0;
                end
            end
            S_INIT: begin
                rng_step = 1'b1;
                init_we  = 1'b1;
                if (ctl_q.slot == LAST_SLOT) begin
                    ctl_d.slot = '0;
                    if (ctl_q.gens_cfg == '0) begin
                        ctl_d.st   = S_DONE;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.st = S_LOAD;
                    end
                end else begin
                    ctl_d.slot = ctl_q.slot + 1'b1;
                end
            end
            S_LOAD: begin
                ctl_d.mask       = '0;
                ctl_d.flips_left = ctl_q.flips_cfg;
                ctl_d.st         = (ctl_q.flips_cfg == '0) ? S_EMIT : S_FLIP;
            end
            S_FLIP: begin
                rng_step         = 1'b1;
                ctl_d.mask       = ctl_q.mask ^ (CHROM_W'(1) << flip_pos);
                ctl_d.flips_left = ctl_q.flips_left - 1'b1;
                if (ctl_q.flips_left == FLIP_W'(1)) begin
                    ctl_d.st = S_EMIT;
                end
            end
            S_EMIT: begin
                if (!q_full) begin
                    q_push           = 1'b1;
                    ctl_d.cand_valid = 1'b1;
                    ctl_d.cand_data  = candidate;
                    if (ctl_q.slot == LAST_SLOT) begin
                        ctl_d.slot      = '0;
                        ctl_d.issue_gen = gen_next;
                        ctl_d.st        = (gen_next == ctl_q.gens_cfg) ? S_DRAIN : S_LOAD;
                    end else begin
                        ctl_d.slot = ctl_q.slot + 1'b1;
                        ctl_d.st   = S_LOAD;
                    end
                end
            end
            S_DRAIN: begin
                if (q_empty) begin
                    ctl_d.st   = S_DONE;
                    ctl_d.done = 1'b1;
                end
            end
            default: ctl_d.st = S_IDLE;
        endcase

        // store write: initial fill or accepted candidate (never together)
        st_we     = init_we || accept;
        st_wslot  = init_we ? ctl_q.slot : head_slot;
        st_wchrom = init_we ? rng_draw : head_chrom;
        st_wfit   = init_we ? '0 : fit_value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: S_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign done       = ctl_q.done;
    assign gen_count  = ctl_q.gen_count;
    assign cand_valid = ctl_q.cand_valid;
    assign cand_data  = ctl_q.cand_data;

endmodule

// File: rtl/hill_climber_chk.sv
module hill_climber_chk #(
    parameter int DEPTH = 4,
    parameter int GEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             cand_valid,
    input logic             fit_valid,
    input logic             done,
    input logic [GEN_W-1:0] gen_count
);

    localparam int CNT_W = $clog2(DEPTH + 2) + 1;

    logic [CNT_W-1:0] outstanding;
    logic             scored;

    assign scored = fit_valid && ((outstanding != '0) || cand_valid);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outstanding <= '0;
        end else begin
            outstanding <= outstanding + CNT_W'(cand_valid) - CNT_W'(scored);
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!cand_valid && !done && gen_count == '0));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |=> !cand_valid);

    a_r6_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding <= CNT_W'(DEPTH));

    a_r8_stray_score: assert property (@(posedge clk) disable iff (!rst_n)
        (fit_valid && outstanding == '0 && !cand_valid && !start) |=> $stable(gen_count));

    a_r9_done_silent: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cand_valid);

    a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    a_r9_gen_step: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_count != $past(gen_count)) |->
            (gen_count == $past(gen_count) + 1'b1 || gen_count == '0));

endmodule

bind hill_climber hill_climber_chk #(
    .DEPTH (FIFO_DEPTH),
    .GEN_W (GEN_W)
) i_hill_climber_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cand_valid (cand_valid),
    .fit_valid  (fit_valid),
    .done       (done),
    .gen_count  (gen_count)
);

// File: tb/test_hill_climber.sv
module test_hill_climber;

    localparam int CW = 24;
    localparam int PN = 16;
    localparam int FW = 16;
    localparam int DP = 4;
    localparam int LW = 4;
    localparam int GW = 16;

    // score table walked by the run loop: higher, equal and lower values
    localparam logic [FW-1:0] FIT_TAB [16] = '{
        16'd10, 16'd5, 16'd10, 16'd30, 16'd0, 16'd200, 16'd199, 16'd200,
        16'd1000, 16'd7, 16'd1000, 16'd1001, 16'd3, 16'hFFFF, 16'hFFFE, 16'd42
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic [31:0]   cfg_seed = '0;
    logic [LW-1:0] cfg_flips = '0;
    logic [GW-1:0] cfg_gens = '0;
    logic          start = 1'b0;
    logic          done;
    logic [GW-1:0] gen_count;
    logic          cand_valid;
    logic [CW-1:0] cand_data;
    logic          fit_valid = 1'b0;
    logic [FW-1:0] fit_value = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    hill_climber #(
        .CHROM_W (CW), .POP_N (PN), .FIT_W (FW),
        .FIFO_DEPTH (DP), .FLIP_W (LW), .GEN_W (GW)
    ) i_hill_climber (
        .clk (clk), .rst_n (rst_n), .cfg_load (cfg_load), .cfg_seed (cfg_seed),
        .cfg_flips (cfg_flips), .cfg_gens (cfg_gens), .start (start),
        .done (done), .gen_count (gen_count), .cand_valid (cand_valid),
        .cand_data (cand_data), .fit_valid (fit_valid), .fit_value (fit_value)
    );

    // model state
    logic [31:0]   m_rng;
    logic [CW-1:0] m_pop [PN];
    logic [FW-1:0] m_fit [PN];
    logic [CW-1:0] q_chrom [64];
    int            q_slot [64];

    function automatic logic [31:0] step_rng(input logic [31:0] s);
        logic [31:0] r;
        r = s >> 1;
        if (s[0]) r = r ^ 32'h80200003;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // one complete search run against the model
    task automatic run_case(input logic [31:0] seed, input logic [LW-1:0] flips,
                            input logic [GW-1:0] gens, input int gap,
                            input bit all_ties, input bit stray,
                            output int max_out);
        int issued = 0, returned = 0, q_head = 0, q_tail = 0, q_cnt = 0;
        int m_gen = 0;
        bit seen_done = 1'b0;
        @(negedge clk);
        cfg_load  = 1'b1;
        cfg_seed  = seed;
        cfg_flips = flips;
        cfg_gens  = gens;
        @(negedge clk);
        cfg_load = 1'b0;
        start    = 1'b1;
        m_rng = (seed == 0) ? 32'd1 : seed;
        for (int i = 0; i < PN; i++) begin
            m_rng    = step_rng(m_rng);
            m_pop[i] = m_rng[CW-1:0];
            m_fit[i] = '0;
        end
        max_out = 0;
        for (int cyc = 1; cyc < 20000 && !seen_done; cyc++) begin
            @(negedge clk);
            start     = 1'b0;
            fit_valid = 1'b0;
            if (cand_valid) begin
                logic [CW-1:0] mask = '0;
                int s = issued % PN;
                for (int f = 0; f < int'(flips); f++) begin
                    int p;
                    m_rng = step_rng(m_rng);
                    p = int'(m_rng[4:0]);
                    if (p >= CW) p = p - CW;
                    mask[p] = ~mask[p];
                end
                check(cand_data == (m_pop[s] ^ mask), "R4", "candidate chromosome",
                      cand_data, m_pop[s] ^ mask);
                q_chrom[q_tail] = cand_data;
                q_slot[q_tail]  = s;
                q_tail = (q_tail + 1) % 64;
                q_cnt++;
                issued++;
                if (q_cnt > max_out) max_out = q_cnt;
                check(q_cnt <= DP, "R6", "outstanding candidates", q_cnt, DP);
            end
            if (q_cnt > 0 && (cyc % gap) == 0) begin
                logic [FW-1:0] v = all_ties ? '0 : FIT_TAB[returned % 16];
                int s = q_slot[q_head];
                if (v > m_fit[s]) begin
                    m_fit[s] = v;
                    m_pop[s] = q_chrom[q_head];
                end
                if (s == PN - 1) m_gen++;
                q_head = (q_head + 1) % 64;
                q_cnt--;
                returned++;
                fit_valid = 1'b1;
                fit_value = v;
            end else if (stray && q_cnt == 0) begin
                fit_valid = 1'b1;
                fit_value = 16'hFFFF;
            end
            if (done) seen_done = 1'b1;
        end
        fit_valid = 1'b0;
        check(seen_done, "R9", "done reached", seen_done, 1);
        check(issued == int'(gens) * PN, "R9", "candidate count", issued, int'(gens) * PN);
        check(gen_count == GW'(m_gen), "R9", "generation counter", gen_count, m_gen);
        check(q_cnt == 0, "R9", "all scored at done", q_cnt, 0);
        @(negedge clk);
        check(done == 1'b1, "R9", "done held", done, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int mo;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cand_valid == 1'b0, "R1", "cand_valid after reset", cand_valid, 0);
        check(done == 1'b0, "R1", "done after reset", done, 0);
        check(gen_count == '0, "R1", "gen_count after reset", gen_count, 0);

        // R2 R3: zero seed becomes 1, zero flips exposes the initial fill
        run_case(32'h0, 4'd0, 16'd1, 1, 1'b0, 1'b0, mo);

        // R4 R6 R7: five flips, slow scores fill the in-flight queue
        run_case(32'h1234ABCD, 4'd5, 16'd3, 20, 1'b0, 1'b0, mo);
        check(mo == DP, "R6", "queue filled before scoring", mo, DP);

        // R7 ties keep parents, R8 stray scores ignored
        run_case(32'hC0FFEE01, 4'd0, 16'd2, 1, 1'b1, 1'b1, mo);

        // R4 with fast scoring and a single flip
        run_case(32'h5A5A0F0F, 4'd1, 16'd2, 1, 1'b0, 1'b1, mo);

        // R9: zero generations
        run_case(32'h00000077, 4'd3, 16'd0, 1, 1'b0, 1'b0, mo);
        check(gen_count == '0, "R9", "no generations run", gen_count, 0);

        finish_run();
    end

endmodule